// File: doc/BRIEF.md
# Serial-Wire Mode Entry Sequencer

This block brings a debug port that powers up in JTAG mode over to serial-wire signalling. It drives a two-wire link: a generated link clock, plus a data line with its own output enable. A one-cycle start pulse makes the block emit the following, one bit per link-clock period:

1. A long run of ones, which resets the line.
2. A 16-bit selection word.
3. A second run of ones.
4. Two idle zeros.

The block updates each bit on a falling link-clock edge, so the bit is already stable when the target samples it on the next rising edge.

After the last bit the block stops the link clock low and releases the data line. It then raises a request to a separate transaction engine, which issues the identification-code read that has to come before any other traffic. When the engine acknowledges, the block pulses done and returns to idle.

The link clock speed is set by a divider value. The block captures this value when it accepts a start, so a slow host clock and a very slow link work as well as a fast one.

Top module: `swsel_sequencer`

## Requirements
- R1: After reset, and whenever idle, busy_o, link_oe_o, link_clk_o, link_dat_o, id_req_o and done_o are all low.
- R2: When start_i is seen while idle, on the next cycle busy_o and link_oe_o are high, link_clk_o is low and link_dat_o is 1.
- R3: Each high phase and each low phase of link_clk_o lasts div_i+1 system clock cycles. div_i is captured when a start is accepted, and later changes to div_i have no effect on a run in progress.
- R4: link_dat_o changes only in the cycle in which link_clk_o falls, so it never changes while the link clock is high.
- R5: The first 56 rising link-clock edges of a run see link_dat_o = 1.
- R6: The next 16 rising edges see the bits 0111100111100111 in that order, the leftmost bit first. This is the same as 16'hE79E taken LSB first.
- R7: The next 56 rising edges see 1 and the final 2 see 0, so a run has exactly 130 rising edges.
- R8: At the falling edge that ends the last bit, the link clock stops low, link_oe_o and link_dat_o go low, and id_req_o goes high. id_req_o stays high until id_ack_i is seen.
- R9: id_ack_i seen while id_req_o is high gives a one-cycle done_o pulse on the next cycle. In that same cycle busy_o and id_req_o are low.
- R10: start_i has no effect while busy_o is high, either during shifting or during the handoff. The run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, taken only while idle |
| div_i | input | 8 | Link half-period minus one, in system cycles |
| id_ack_i | input | 1 | Transaction engine has finished the identification read |
| link_clk_o | output | 1 | Generated link clock |
| link_dat_o | output | 1 | Link data bit |
| link_oe_o | output | 1 | Link data output enable |
| busy_o | output | 1 | Run in progress, from start until done |
| id_req_o | output | 1 | Request to the transaction engine for the identification read |
| done_o | output | 1 | One-cycle pulse when the handoff completes |

## Verification
The sequence is run with divider values 0, 1, 2, 3 and 5. The bits seen at every rising link-clock edge are compared with a sequence the bench computes, and the length of every half-period is measured. Comparing across divider settings separates a correct half-period from an off-by-one in the divider count.

Three further runs target particular inputs:
- A run that changes div_i part-way through shows whether the divider value is captured or followed live.
- A start pulse during shifting and another during the handoff would each restart or corrupt the run, and this shows up as a wrong count of rising edges or as bit mismatches.
- Varying the acknowledge delay confirms that the request holds and that the done pulse tracks the acknowledge.

// File: rtl/swsel_pkg.sv
package swsel_pkg;

  // Run phases of the sequencer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_HAND  = 2'd2
  } phase_e;

  // Selection word, LSB is the first bit on the wire
  localparam logic [15:0] SEL_WORD_DEF = 16'hE79E;

endpackage

// File: rtl/swsel_clkdiv.sv
module swsel_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lclk_o,
  output logic             fall_o
);

  localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

  logic [DIV_W-1:0] hcnt_q, hcnt_d;
  logic             lclk_q, lclk_d;
  logic             hit;

  assign hit = run_i && (hcnt_q == div_i);

  always_comb begin
    hcnt_d = hcnt_q;
    lclk_d = lclk_q;
    if (!run_i) begin
      hcnt_d = '0;
      lclk_d = 1'b0;
    end else if (hit) begin
      hcnt_d = '0;
      lclk_d = ~lclk_q;
    end else begin
      hcnt_d = hcnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      lclk_q <= lclk_d;
    end
  end

  assign lclk_o = lclk_q;
  assign fall_o = hit && lclk_q;

  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !lclk_o);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && $stable(div_i) |-> hcnt_q <= div_i);

endmodule

// File: rtl/swsel_pattern.sv
module swsel_pattern #(
  parameter int          RST_LEN  = 56,
  parameter int          SEL_LEN  = 16,
  parameter int          IDLE_LEN = 2,
  parameter logic [15:0] SEL_WORD = swsel_pkg::SEL_WORD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic bit_o,
  output logic last_o
);

  localparam int TOTAL = 2 * RST_LEN + SEL_LEN + IDLE_LEN;
  localparam int IDX_W = $clog2(TOTAL + 1);
  localparam int SEL_W = (SEL_LEN > 1) ? $clog2(SEL_LEN) : 1;

  localparam logic [IDX_W-1:0] B_SEL  = IDX_W'(RST_LEN);
  localparam logic [IDX_W-1:0] B_RST2 = IDX_W'(RST_LEN + SEL_LEN);
  localparam logic [IDX_W-1:0] B_IDLE = IDX_W'(2 * RST_LEN + SEL_LEN);
  localparam logic [IDX_W-1:0] B_LAST = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SEL_W-1:0] sel_idx;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)
      idx_d = '0;
    else if (adv_i && (idx_q != B_LAST))
      idx_d = idx_q + IDX_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign sel_idx = SEL_W'(idx_q - B_SEL);

  always_comb begin
    if (idx_q < B_SEL)
      bit_o = 1'b1;
    else if (idx_q < B_RST2)
      bit_o = SEL_WORD[sel_idx];
    else if (idx_q < B_IDLE)
      bit_o = 1'b1;
    else
      bit_o = 1'b0;
  end

  assign last_o = (idx_q == B_LAST);

  // R7
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !clr_i |=> last_o);

  // R5
  clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> bit_o);

endmodule

// File: rtl/swsel_ctrl.sv
module swsel_ctrl
  import swsel_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             last_i,
  input  logic             fall_i,
  input  logic             ack_i,
  output logic             clr_o,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output phase_e           phase_o,
  output logic             done_o
);

  phase_e           phase_q, phase_d;
  logic [DIV_W-1:0] div_q;
  logic             div_en;
  logic             done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    clr_o   = 1'b0;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SHIFT;
          clr_o   = 1'b1;
        end
      end
      PH_SHIFT: begin
        if (fall_i && last_i) phase_d = PH_HAND;
      end
      PH_HAND: begin
        if (ack_i) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign div_en = clr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_i;
  end

  assign run_o   = (phase_q == PH_SHIFT);
  assign div_o   = div_q;
  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHIFT) && start_i && !fall_i |=> phase_q == PH_SHIFT);

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHIFT) && $past(phase_q == PH_SHIFT) |-> $stable(div_q));

endmodule

// File: rtl/swsel_sequencer.sv
module swsel_sequencer
  import swsel_pkg::*;
#(
  parameter int          DIV_W    = 8,
  parameter int          RST_LEN  = 56,
  parameter int          SEL_LEN  = 16,
  parameter int          IDLE_LEN = 2,
  parameter logic [15:0] SEL_WORD = SEL_WORD_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             id_ack_i,
  output logic             link_clk_o,
  output logic             link_dat_o,
  output logic             link_oe_o,
  output logic             busy_o,
  output logic             id_req_o,
  output logic             done_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             clr, run, fall, last, pat_bit;
  logic [DIV_W-1:0] div_run;
  phase_e           phase;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  swsel_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .div_i   (div_i),
    .last_i  (last),
    .fall_i  (fall),
    .ack_i   (id_ack_i),
    .clr_o   (clr),
    .run_o   (run),
    .div_o   (div_run),
    .phase_o (phase),
    .done_o  (done_o)
  );

  swsel_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .div_i  (div_run),
    .lclk_o (link_clk_o),
    .fall_o (fall)
  );

  swsel_pattern #(
    .RST_LEN  (RST_LEN),
    .SEL_LEN  (SEL_LEN),
    .IDLE_LEN (IDLE_LEN),
    .SEL_WORD (SEL_WORD)
  ) pattern_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .adv_i  (fall),
    .bit_o  (pat_bit),
    .last_o (last)
  );

  assign link_oe_o  = (phase == PH_SHIFT);
  assign link_dat_o = link_oe_o & pat_bit;
  assign busy_o     = (phase != PH_IDLE);
  assign id_req_o   = (phase == PH_HAND);

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o && $past(busy_o) && (link_dat_o != $past(link_dat_o)) |-> !link_clk_o);

  // R8
  handoff_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(id_req_o) |-> $past(link_clk_o) && !link_clk_o && !link_oe_o);

  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o && $past(id_req_o) && $past(id_ack_i));

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> link_oe_o && link_dat_o && !link_clk_o);

  // R8
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({link_oe_o, id_req_o, done_o}));

endmodule

// File: tb/swsel_sequencer_tb.sv
module swsel_sequencer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] div_i;
  logic       id_ack_i;
  logic       link_clk_o, link_dat_o, link_oe_o, busy_o, id_req_o, done_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [15:0] SEL_MSB_FIRST = 16'b0111100111100111;
  localparam int N_RST = 56;
  localparam int N_SEL = 16;
  localparam int N_BITS = 2 * N_RST + N_SEL + 2;

  swsel_sequencer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .div_i      (div_i),
    .id_ack_i   (id_ack_i),
    .link_clk_o (link_clk_o),
    .link_dat_o (link_dat_o),
    .link_oe_o  (link_oe_o),
    .busy_o     (busy_o),
    .id_req_o   (id_req_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k);
    if (k < N_RST) return 1'b1;
    if (k < N_RST + N_SEL) return SEL_MSB_FIRST[N_SEL - 1 - (k - N_RST)];
    if (k < 2 * N_RST + N_SEL) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_case(input int dv, input bit poke_start, input bit poke_div, input int ack_wait);
    int   rises = 0;
    int   n = 0;
    int   hlen;
    int   bad_half = 0, bad_stab = 0;
    int   bad_r5 = 0, bad_r6 = 0, bad_r7 = 0;
    logic pc, pd;
    @(negedge clk);
    div_i = 8'(dv);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2 first state after accept
    chk(busy_o && link_oe_o && link_dat_o && !link_clk_o, "R2 start state",
        {busy_o, link_oe_o, link_dat_o, link_clk_o}, 4'b1110);
    pc = link_clk_o;
    pd = link_dat_o;
    hlen = 1;
    while (!id_req_o && n < 20000) begin
      @(negedge clk);
      n++;
      start_i = (poke_start && n == 40);
      if (poke_div && n == 25) div_i = 8'(dv + 3);
      if (link_clk_o != pc) begin
        if (hlen != dv + 1) bad_half++;
        hlen = 1;
        if (link_clk_o) begin
          if (link_dat_o !== exp_bit(rises)) begin
            if (rises < N_RST) bad_r5++;
            else if (rises < N_RST + N_SEL) bad_r6++;
            else bad_r7++;
          end
          rises++;
        end
      end else begin
        hlen++;
      end
      if (link_dat_o != pd && link_clk_o) bad_stab++;
      pc = link_clk_o;
      pd = link_dat_o;
    end
    start_i = 1'b0;
    div_i = 8'(dv);
    chk(bad_r5 == 0, "R5 reset ones", bad_r5, 0);
    chk(bad_r6 == 0, "R6 select word", bad_r6, 0);
    chk(bad_r7 == 0, "R7 second reset and idle", bad_r7, 0);
    chk(rises == N_BITS, "R7 rising edge count", rises, N_BITS);
    chk(bad_half == 0, "R3 half period", bad_half, 0);
    chk(bad_stab == 0, "R4 data change while high", bad_stab, 0);
    chk(id_req_o && !link_oe_o && !link_clk_o && !link_dat_o && busy_o, "R8 handoff state",
        {id_req_o, link_oe_o, link_clk_o, link_dat_o, busy_o}, 5'b10001);
    for (int w = 0; w < ack_wait; w++) begin
      start_i = poke_start;
      @(negedge clk);
      start_i = 1'b0;
      // R8 request held, R10 start ignored in handoff
      chk(id_req_o && busy_o && !done_o && !link_oe_o && !link_clk_o, "R8 R10 handoff hold",
          {id_req_o, busy_o, done_o, link_oe_o, link_clk_o}, 5'b11000);
    end
    id_ack_i = 1'b1;
    @(negedge clk);
    id_ack_i = 1'b0;
    chk(done_o && !busy_o && !id_req_o, "R9 done pulse", {done_o, busy_o, id_req_o}, 3'b100);
    @(negedge clk);
    chk(!done_o && !busy_o && !link_oe_o && !link_dat_o && !link_clk_o, "R9 R1 back to idle",
        {done_o, busy_o, link_oe_o, link_dat_o, link_clk_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    div_i = 8'd0;
    id_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !link_oe_o && !link_clk_o && !link_dat_o && !id_req_o && !done_o,
        "R1 reset state",
        {busy_o, link_oe_o, link_clk_o, link_dat_o, id_req_o, done_o}, 0);
    run_case(0, 1'b0, 1'b0, 0);
    run_case(1, 1'b0, 1'b0, 1);
    run_case(2, 1'b0, 1'b0, 2);
    run_case(3, 1'b0, 1'b0, 0);
    run_case(5, 1'b0, 1'b0, 3);
    // R10 start pokes during shift and handoff
    run_case(2, 1'b1, 1'b0, 2);
    // R3 divider change mid-run ignored
    run_case(1, 1'b0, 1'b1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule